// File: doc/BRIEF.md
# Disk Sector CRC Generator and Checker

This block keeps the 16-bit cyclic check word that guards the identification and data fields of a floppy disk track. Bytes are presented one at a time with a valid strobe, most significant bit first. The running remainder is visible on every cycle, and a flag shows when it is zero. A field-start strobe loads the register with all ones, so the span covered by a field begins with the first byte of its address mark.

One register serves both directions of transfer. On a write, the host feeds the mark and the body of the field and then raises an emit request. The block then drives the two check bytes out on consecutive cycles, high byte first. While it does so, it folds them back into its own register, so the register reads zero once the second byte has gone. On a read, the host feeds the mark, the body and the two recorded check bytes. A zero register at the end means the field arrived intact.

Top module: `dskcrc_engine`

## Requirements
- R1: After reset `crc_o` reads 16'hFFFF and `emit_valid_o` is low.
- R2: A cycle with `field_start_i` high leaves `crc_o` at 16'hFFFF after the next clock edge. It overrides a data byte presented in the same cycle, and it cancels an emission in progress, so `emit_valid_o` is low from that edge on.
- R3: A cycle with `byte_valid_i` high, no emission running and no emit request updates `crc_o` at the next edge. The new value is the old one after eight serial shifts with polynomial 16'h1021, taking `byte_i` bit 7 first. The nine ASCII digits "123456789" fed after a preset give 16'h29B1.
- R4: With no field start, no accepted byte and no emission, `crc_o` holds its value.
- R5: `crc_ok_o` is high exactly when `crc_o` is 16'h0000.
- R6: Check mode: feeding a preset field and then its correct check bytes (high, then low) leaves `crc_o` at zero. Changing any single bit of the field leaves it nonzero.
- R7: An emit request while idle makes `emit_valid_o` high for exactly the next two cycles. `emit_byte_o` carries bits 15:8 of the remainder as it stood at the request in the first cycle, and bits 7:0 in the second.
- R8: After the second emitted byte, `crc_o` reads zero.
- R9: While an emission runs, `byte_valid_i` and `emit_req_i` have no effect. In the cycle of an emit request, a byte presented alongside it is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| field_start_i | input | 1 | Preset the register to all ones |
| byte_valid_i | input | 1 | Strobe for `byte_i` |
| byte_i | input | 8 | Field byte, bit 7 first |
| emit_req_i | input | 1 | Start output of the two check bytes |
| crc_o | output | 16 | Current remainder |
| crc_ok_o | output | 1 | High when the remainder is zero |
| emit_valid_o | output | 1 | `emit_byte_o` carries a check byte |
| emit_byte_o | output | 8 | Check byte being emitted |

## Verification
Every register result is due one clock edge after the cycle that caused it. An accepted byte or a preset shows on `crc_o` at that edge. The first check byte appears one edge after the request, the second one edge later, and the zero remainder one edge after that. `crc_ok_o` follows `crc_o` with no further delay. The bench drives inputs on falling edges and samples on the next falling edge, so each check falls in the cycle just after the rising edge that produced its result. Emissions are checked across three consecutive falling edges. The internal reset release takes two edges, and the bench waits three before its first check.

// File: rtl/dskcrc_pkg.sv
package dskcrc_pkg;
  localparam int unsigned CRC_W_DEF  = 16;
  localparam int unsigned DATA_W_DEF = 8;
  localparam logic [15:0] POLY_DEF   = 16'h1021;
  localparam logic [15:0] PRESET_DEF = 16'hFFFF;
  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/dskcrc_step.sv
module dskcrc_step #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [CRC_W-1:0]  crc_o
);
  // one stage per data bit, most significant bit enters first
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = crc_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][CRC_W-1] ^ din_i[DATA_W-1-i];
    assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/dskcrc_reg.sv
module dskcrc_reg #(
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preset_i,
  input  logic             load_i,
  input  logic [CRC_W-1:0] next_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             crc_en;

  always_comb begin
    crc_en = preset_i | load_i;
    crc_d  = preset_i ? PRESET : next_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= PRESET;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  AST_PRESET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> crc_q == PRESET);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preset_i && !load_i) |=> $stable(crc_q));  // R4
endmodule

// File: rtl/dskcrc_emit.sv
module dskcrc_emit #(
  parameter int unsigned BEATS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic req_i,
  output logic busy_o,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(BEATS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (start_i)             cnt_d = '0;
    else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    else if (req_i)          cnt_d = CNT_W'(BEATS);
    else begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = cnt_q != '0;
  assign last_o = cnt_q == CNT_W'(1);

  AST_EMIT_BEGINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !start_i) |=> busy_o);  // R7
  AST_EMIT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !busy_o);  // R2
endmodule

// File: rtl/dskcrc_engine.sv
module dskcrc_engine
  import dskcrc_pkg::*;
#(
  parameter int unsigned CRC_W  = CRC_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter logic [CRC_W-1:0] POLY   = POLY_DEF,
  parameter logic [CRC_W-1:0] PRESET = PRESET_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              field_start_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              emit_req_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              crc_ok_o,
  output logic              emit_valid_o,
  output logic [DATA_W-1:0] emit_byte_o
);
  localparam int unsigned BEATS = CRC_W / DATA_W;

  // reset: asserted at once, released after RST_STAGES edges
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  logic              busy, last;
  logic              take_byte, load_en;
  logic [DATA_W-1:0] top_byte, step_din;
  logic [CRC_W-1:0]  crc_cur, crc_next;

  assign top_byte = crc_cur[CRC_W-1 -: DATA_W];

  // during emission the register folds its own top byte back in, which
  // shifts the next check byte into the top position
  always_comb begin
    take_byte = byte_valid_i & ~busy & ~emit_req_i;
    load_en   = busy | take_byte;
    step_din  = busy ? top_byte : byte_i;
  end

  dskcrc_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_step (
    .crc_i (crc_cur),
    .din_i (step_din),
    .crc_o (crc_next)
  );

  dskcrc_reg #(.CRC_W(CRC_W), .PRESET(PRESET)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .preset_i (field_start_i),
    .load_i   (load_en),
    .next_i   (crc_next),
    .crc_o    (crc_cur)
  );

  dskcrc_emit #(.BEATS(BEATS)) u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .start_i (field_start_i),
    .req_i   (emit_req_i),
    .busy_o  (busy),
    .last_o  (last)
  );

  assign crc_o        = crc_cur;
  assign crc_ok_o     = crc_cur == '0;
  assign emit_valid_o = busy;
  assign emit_byte_o  = top_byte;

  AST_EMIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (last && !field_start_i) |=> crc_o == '0);  // R8
  AST_EMIT_STEADY: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (emit_valid_o && !last && !field_start_i) |=> emit_valid_o);  // R7
endmodule

// File: tb/dskcrc_engine_bench.sv
module dskcrc_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       field_start, byte_valid, emit_req;
  logic [7:0] byte_in;
  logic [15:0] crc;
  logic       crc_ok, emit_valid;
  logic [7:0] emit_byte;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dskcrc_engine u_dskcrc_engine (
    .clk_i(clk), .rst_ni(rst_n), .field_start_i(field_start),
    .byte_valid_i(byte_valid), .byte_i(byte_in), .emit_req_i(emit_req),
    .crc_o(crc), .crc_ok_o(crc_ok), .emit_valid_o(emit_valid),
    .emit_byte_o(emit_byte)
  );

  function automatic logic [15:0] model_step(logic [15:0] c, logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic preset();
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  task automatic feed(logic [7:0] b);
    byte_valid = 1'b1; byte_in = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  // emission with optional junk bytes driven throughout; checks both beats
  task automatic emit_and_check(logic [15:0] exp_crc, bit junk);
    emit_req = 1'b1;
    byte_valid = junk; byte_in = 8'h5A;
    @(negedge clk);
    emit_req = junk;
    chk("R7 first beat valid", 32'(emit_valid), 32'd1);
    chk("R7 high byte", 32'(emit_byte), 32'(exp_crc[15:8]));
    @(negedge clk);
    chk("R7 second beat valid", 32'(emit_valid), 32'd1);
    chk("R7 low byte", 32'(emit_byte), 32'(exp_crc[7:0]));
    byte_valid = 1'b0; emit_req = 1'b0;
    @(negedge clk);
    chk("R7 emission ends", 32'(emit_valid), 32'd0);
    chk("R8 zero after emission", 32'(crc), 32'd0);
    chk("R5 ok at zero", 32'(crc_ok), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] m;
    logic [7:0]  field [8];
    logic [31:0] lfsr;
    string digits;
    rst_n = 1'b0; field_start = 0; byte_valid = 0; emit_req = 0; byte_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset crc", 32'(crc), 32'hFFFF);
    chk("R1 reset emit", 32'(emit_valid), 32'd0);

    // R3 exhaustive single byte after preset
    for (int v = 0; v < 256; v++) begin
      preset();
      chk("R2 preset", 32'(crc), 32'hFFFF);
      feed(8'(v));
      m = model_step(16'hFFFF, 8'(v));
      chk("R3 byte update", 32'(crc), 32'(m));
      chk("R5 ok flag", 32'(crc_ok), 32'(m == 16'h0));
    end

    // R3 known string
    preset();
    digits = "123456789";
    for (int i = 0; i < 9; i++) feed(digits[i]);
    chk("R3 known value", 32'(crc), 32'h29B1);

    // R4 hold over idle cycles
    repeat (5) @(negedge clk);
    chk("R4 hold", 32'(crc), 32'h29B1);

    // R2 preset beats a same-cycle byte
    field_start = 1'b1; byte_valid = 1'b1; byte_in = 8'h33;
    @(negedge clk);
    field_start = 1'b0; byte_valid = 1'b0;
    chk("R2 preset priority", 32'(crc), 32'hFFFF);

    // R6/R7/R8/R9 over pseudo-random fields starting with address mark
    lfsr = 32'h1ACE_B00C;
    for (int t = 0; t < 64; t++) begin
      field[0] = 8'hA1; field[1] = 8'hA1; field[2] = 8'hA1; field[3] = 8'hFE;
      for (int i = 4; i < 8; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        field[i] = lfsr[7:0];
      end
      m = 16'hFFFF;
      preset();
      for (int i = 0; i < 8; i++) begin
        feed(field[i]);
        m = model_step(m, field[i]);
      end
      chk("R3 field value", 32'(crc), 32'(m));
      // R9 junk bytes and requests during emission are ignored
      emit_and_check(m, t[0]);
      // check mode: correct bytes
      preset();
      for (int i = 0; i < 8; i++) feed(field[i]);
      feed(m[15:8]); feed(m[7:0]);
      chk("R6 good field zero", 32'(crc), 32'd0);
      // check mode: single bit flip
      preset();
      for (int i = 0; i < 8; i++) feed(i == (t % 8) ? field[i] ^ (8'h1 << (t % 8)) : field[i]);
      feed(m[15:8]); feed(m[7:0]);
      chk("R6 corrupted nonzero", 32'(crc != 16'h0), 32'd1);
      chk("R5 ok low on error", 32'(crc_ok), 32'd0);
    end

    // R9 byte with emit request in same idle cycle not taken
    preset();
    feed(8'h42);
    m = model_step(16'hFFFF, 8'h42);
    emit_and_check(m, 1'b1);

    // R2 preset cancels emission
    preset(); feed(8'h10);
    emit_req = 1'b1;
    @(negedge clk);
    emit_req = 1'b0;
    preset();
    chk("R2 emission cancelled", 32'(emit_valid), 32'd0);
    chk("R2 crc after cancel", 32'(crc), 32'hFFFF);
    @(negedge clk);
    chk("R2 stays idle", 32'(emit_valid), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule